// File: doc/BRIEF.md
# Floating-point coprocessor instruction class decoder

This block looks at one 32-bit instruction word that a core has fetched from the floating-point coprocessor space. It works out which of a small, sparse set of supported operations the word encodes, and it pulls out the register index fields that an execution stage needs. It does not run the operations. A word is recognised only when every fixed bit of one pattern matches. Every other word in the coprocessor space raises an unsupported flag, so the core can trap.

Two instruction groups are decoded. The first is the data/transfer group: type 7, with bit 24 clear. The second is the paired-transfer group: type 6. Single-precision register indices are 5 bits wide. Each one joins a 4-bit field, taken as the upper part, with a separate extra bit, taken as the least significant bit. Which field and which extra bit are used depends on the operation. The parameter `REG_OUT` sets the latency. With 0, the outputs are purely combinational. With 1, the outputs come from a register stage that resets to the no-op state.

Top module: `fpx_insn_decoder`

## Requirements
- R1: A word whose bits 27..25 are neither 6 nor 7, or whose bits 27..25 are 7 with bit 24 set, gives operation code 0 (none) with the unsupported flag low.
- R2: A type-7 word (bit 24 clear) with bits 23 and 21 clear, bits 11..8 = 0xA, bits 6..5 = 0, bit 4 = 1 and bits 3..0 = 0 is a single/core move. Bit 20 = 0 gives code 1 (core to single) and bit 20 = 1 gives code 2 (single to core). The single index is {bits 19..16, bit 7}.
- R3: With bit 23 = 1, bits 11..9 = 5, bit 8 = 1, bit 6 = 1 and bit 4 = 0: bits 21..19 = 7 with bits 18..16 = 5 gives code 4 (double to int), with single index {bits 15..12, bit 22}. Bits 21..19 = 7 with bits 18..16 = 0 and bit 7 = 1 gives code 3 (int to double), with single index {bits 3..0, bit 5}.
- R4: With bit 23 = 1, bits 21..20 = 0, bits 11..9 = 5, bit 8 = 1, bit 6 = 0 and bit 4 = 0, the code is 8 (divide). With bit 23 = 0, bit 21 = 1, bits 11..9 = 5, bit 8 = 1 and bit 4 = 0, the code depends on bit 20 and bit 6. Bit 20 = 1 with bit 6 = 0 gives code 5 (add). Bit 20 = 1 with bit 6 = 1 gives code 6 (subtract). Bit 20 = 0 with bit 6 = 0 gives code 7 (multiply). Bit 20 = 0 with bit 6 = 1 is unsupported.
- R5: With bit 23 = 1, bits 21..20 = 3, bits 19..16 = 4, bits 11..9 = 5, bit 8 = 1, bit 6 = 1 and bit 4 = 0, the code is 9 (compare).
- R6: Bits 23..20 = 0xF, bits 19..16 = 1, bits 11..8 = 0xA, bits 7..5 = 0, bit 4 = 1 and bits 3..0 = 0 give code 10 (status to flags) only when bits 15..12 = 0xF. Any other value in bits 15..12 is unsupported.
- R7: A type-6 word with bits 27..24 = 0xC, bit 23 = 0, bit 22 = 1, bits 11..8 = 0xB, bits 7..6 = 0 and bit 4 = 1 gives code 11 (two core registers to double) when bit 20 = 0, and code 12 (double to two core registers) when bit 20 = 1.
- R8: Any other word in the coprocessor space raises the unsupported flag and gives code 0.
- R9: The raw fields are always output, whatever the operation: core T = bits 15..12, core N = bits 19..16, double D = bits 15..12, double N = bits 19..16, double M = bits 3..0. The single index is 0 for every code other than 1, 2, 3 and 4.
- R10: With REG_OUT = 0, the outputs follow the word in the same cycle. With REG_OUT = 1, they show the decode of the word sampled at the previous rising edge. While reset is high, all registered outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word to decode |
| op_o | output | 4 | Operation code, 0 = none |
| unsup_o | output | 1 | Word is in coprocessor space but matches no pattern |
| core_t_o | output | 4 | Core register field, bits 15..12 |
| core_n_o | output | 4 | Second core register field, bits 19..16 |
| dreg_d_o | output | 4 | Double destination index, bits 15..12 |
| dreg_n_o | output | 4 | Double first-source index, bits 19..16 |
| dreg_m_o | output | 4 | Double second-source index, bits 3..0 |
| sreg_o | output | 5 | Single register index for codes 1 to 4, else 0 |

## Verification
The bench builds two copies side by side from the same word: one with REG_OUT = 0 and one with REG_OUT = 1. This exercises both the same-cycle path and the one-cycle registered path, including the reset hold, against one expected decode. Templates force each supported pattern and leave every other bit random, so the single-index extra bits, both directions of each transfer, and the unsupported fourth arithmetic combination are all reached. Near-miss words, with one fixed bit flipped, probe the edges of each pattern.

// File: rtl/fpx_dec_pkg.sv
package fpx_dec_pkg;

    localparam int WORD_W  = 32;
    localparam int FIELD_W = 4;
    localparam int SIDX_W  = FIELD_W + 1;
    localparam int OP_W    = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NONE      = 4'd0,
        OP_CORE_TO_S = 4'd1,
        OP_S_TO_CORE = 4'd2,
        OP_I_TO_D    = 4'd3,
        OP_D_TO_I    = 4'd4,
        OP_DADD      = 4'd5,
        OP_DSUB      = 4'd6,
        OP_DMUL      = 4'd7,
        OP_DDIV      = 4'd8,
        OP_DCMP      = 4'd9,
        OP_FLAGS     = 4'd10,
        OP_CC_TO_D   = 4'd11,
        OP_D_TO_CC   = 4'd12
    } fp_op_e;

    typedef struct packed {
        logic [FIELD_W-1:0] rt;
        logic [FIELD_W-1:0] rn;
        logic [FIELD_W-1:0] vd;
        logic [FIELD_W-1:0] vn;
        logic [FIELD_W-1:0] vm;
        logic               xn;
        logic               xd;
        logic               xm;
    } fields_s;

    typedef struct packed {
        fp_op_e             op;
        logic               unsup;
        logic [FIELD_W-1:0] rt;
        logic [FIELD_W-1:0] rn;
        logic [FIELD_W-1:0] vd;
        logic [FIELD_W-1:0] vn;
        logic [FIELD_W-1:0] vm;
        logic [SIDX_W-1:0]  sidx;
    } dec_s;

    function automatic logic [SIDX_W-1:0] join_sidx(logic [FIELD_W-1:0] hi, logic lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/fpx_field_split.sv
module fpx_field_split
    import fpx_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fields_s           fld_o
);
    logic unused_bits;
    assign unused_bits = ^{word_i[31:23], word_i[21:20], word_i[11:8], word_i[6], word_i[4]};

    always_comb begin
        fld_o.rt = word_i[15:12];
        fld_o.rn = word_i[19:16];
        fld_o.vd = word_i[15:12];
        fld_o.vn = word_i[19:16];
        fld_o.vm = word_i[3:0];
        fld_o.xn = word_i[7];
        fld_o.xd = word_i[22];
        fld_o.xm = word_i[5];
    end
endmodule

// File: rtl/fpx_pattern_match.sv
module fpx_pattern_match
    import fpx_dec_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fp_op_e            op_o,
    output logic              unsup_o
);
    logic unused_cond;
    assign unused_cond = ^word_i[31:28];

    logic grp6, grp7;
    logic fx_95, arith_base, mov_base;
    assign grp6 = (word_i[27:25] == 3'd6);
    assign grp7 = (word_i[27:25] == 3'd7) && !word_i[24];
    assign fx_95 = (word_i[11:9] == 3'd5) && word_i[8] && !word_i[4];
    assign arith_base = fx_95;
    assign mov_base = (word_i[11:8] == 4'hA) && (word_i[6:5] == 2'd0)
                      && word_i[4] && (word_i[3:0] == 4'd0);

    always_comb begin
        op_o    = OP_NONE;
        unsup_o = 1'b0;
        if (grp6) begin
            unsup_o = 1'b1;
            if (!word_i[24] && !word_i[23] && word_i[22] &&
                (word_i[11:8] == 4'hB) && (word_i[7:6] == 2'd0) && word_i[4]) begin
                unsup_o = 1'b0;
                op_o    = word_i[20] ? OP_D_TO_CC : OP_CC_TO_D;
            end
        end else if (grp7) begin
            unsup_o = 1'b1;
            if (word_i[23]) begin
                if ((word_i[21:19] == 3'd7) && (word_i[18:16] == 3'd5) && fx_95 && word_i[6]) begin
                    op_o = OP_D_TO_I;
                end else if ((word_i[21:19] == 3'd7) && (word_i[18:16] == 3'd0) && fx_95 &&
                             word_i[7] && word_i[6]) begin
                    op_o = OP_I_TO_D;
                end else if ((word_i[21:20] == 2'd0) && fx_95 && !word_i[6]) begin
                    op_o = OP_DDIV;
                end else if ((word_i[21:20] == 2'd3) && (word_i[19:16] == 4'd4) && fx_95 &&
                             word_i[6]) begin
                    op_o = OP_DCMP;
                end else if ((word_i[23:20] == 4'hF) && (word_i[19:16] == 4'd1) &&
                             (word_i[11:8] == 4'hA) && (word_i[7:5] == 3'd0) && word_i[4] &&
                             (word_i[3:0] == 4'd0) && (word_i[15:12] == 4'hF)) begin
                    op_o = OP_FLAGS;
                end
            end else if (word_i[21]) begin
                if (arith_base) begin
                    case ({word_i[20], word_i[6]})
                        2'b10:   op_o = OP_DADD;
                        2'b11:   op_o = OP_DSUB;
                        2'b00:   op_o = OP_DMUL;
                        default: op_o = OP_NONE;
                    endcase
                end
            end else if (mov_base) begin
                op_o = word_i[20] ? OP_S_TO_CORE : OP_CORE_TO_S;
            end
            if (op_o != OP_NONE) unsup_o = 1'b0;
        end
    end
endmodule

// File: rtl/fpx_sidx_select.sv
module fpx_sidx_select
    import fpx_dec_pkg::*;
(
    input  fp_op_e             op_i,
    input  fields_s            fld_i,
    output logic [SIDX_W-1:0]  sidx_o
);
    always_comb begin
        unique case (op_i)
            OP_CORE_TO_S, OP_S_TO_CORE: sidx_o = join_sidx(fld_i.vn, fld_i.xn);
            OP_D_TO_I:                  sidx_o = join_sidx(fld_i.vd, fld_i.xd);
            OP_I_TO_D:                  sidx_o = join_sidx(fld_i.vm, fld_i.xm);
            default:                    sidx_o = '0;
        endcase
    end
endmodule

// File: rtl/fpx_out_stage.sv
module fpx_out_stage
    import fpx_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  dec_s d_i,
    output dec_s q_o
);
    generate
        if (REG_OUT) begin : g_reg
            dec_s q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/fpx_insn_decoder.sv
module fpx_insn_decoder
    import fpx_dec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_i,
    output logic [3:0]  op_o,
    output logic        unsup_o,
    output logic [3:0]  core_t_o,
    output logic [3:0]  core_n_o,
    output logic [3:0]  dreg_d_o,
    output logic [3:0]  dreg_n_o,
    output logic [3:0]  dreg_m_o,
    output logic [4:0]  sreg_o
);
    fields_s fld;
    fp_op_e  op_c;
    logic    unsup_c;
    logic [SIDX_W-1:0] sidx_c;
    dec_s    dec_c, dec_q;

    fpx_field_split u_split (.word_i(instr_i), .fld_o(fld));
    fpx_pattern_match u_match (.word_i(instr_i), .op_o(op_c), .unsup_o(unsup_c));
    fpx_sidx_select u_sidx (.op_i(op_c), .fld_i(fld), .sidx_o(sidx_c));

    always_comb begin
        dec_c.op    = op_c;
        dec_c.unsup = unsup_c;
        dec_c.rt    = fld.rt;
        dec_c.rn    = fld.rn;
        dec_c.vd    = fld.vd;
        dec_c.vn    = fld.vn;
        dec_c.vm    = fld.vm;
        dec_c.sidx  = sidx_c;
    end

    fpx_out_stage #(.REG_OUT(REG_OUT)) u_out (.clk(clk), .rst(rst), .d_i(dec_c), .q_o(dec_q));

    assign op_o     = dec_q.op;
    assign unsup_o  = dec_q.unsup;
    assign core_t_o = dec_q.rt;
    assign core_n_o = dec_q.rn;
    assign dreg_d_o = dec_q.vd;
    assign dreg_n_o = dec_q.vn;
    assign dreg_m_o = dec_q.vm;
    assign sreg_o   = dec_q.sidx;
endmodule

// File: rtl/fpx_insn_decoder_chk.sv
module fpx_insn_decoder_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr_i,
    input logic [3:0]  op_o,
    input logic        unsup_o,
    input logic [3:0]  core_t_o,
    input logic [3:0]  dreg_m_o,
    input logic [4:0]  sreg_o
);
    logic [31:0] instr_q;
    logic        seen;
    logic [31:0] view;
    logic        outside;
    logic        unused_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            seen    <= 1'b0;
        end else begin
            instr_q <= instr_i;
            seen    <= 1'b1;
        end
    end

    assign view    = REG_OUT ? instr_q : instr_i;
    assign outside = !((view[27:25] == 3'd6) || ((view[27:25] == 3'd7) && !view[24]));
    assign unused_w = ^{view[31:28], view[23:21], view[19:16], view[11:4]};

    p_unsup_noop_r8: assert property (@(posedge clk) disable iff (rst)
        unsup_o |-> (op_o == 4'd0));

    p_outside_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (seen && outside) |-> (op_o == 4'd0 && !unsup_o));

    p_sidx_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (op_o == 4'd0 || op_o > 4'd4) |-> (sreg_o == 5'd0));

    p_fields_r9: assert property (@(posedge clk) disable iff (rst)
        seen |-> (core_t_o == view[15:12] && dreg_m_o == view[3:0]));

    p_pair_dir_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && (op_o == 4'd11 || op_o == 4'd12)) |->
            (view[27:25] == 3'd6 && view[20] == (op_o == 4'd12)));

    p_status_rt_r6: assert property (@(posedge clk) disable iff (rst)
        (seen && op_o == 4'd10) |-> (view[15:12] == 4'hF));
endmodule

bind fpx_insn_decoder fpx_insn_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .instr_i(instr_i), .op_o(op_o), .unsup_o(unsup_o),
    .core_t_o(core_t_o), .dreg_m_o(dreg_m_o), .sreg_o(sreg_o)
);

// File: tb/fpx_insn_decoder_tb_top.sv
module fpx_insn_decoder_tb_top;
    import fpx_dec_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] instr = 32'd0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    logic [3:0] r_op, c_op, r_ct, c_ct, r_cn, c_cn, r_dd, c_dd, r_dn, c_dn, r_dm, c_dm;
    logic       r_un, c_un;
    logic [4:0] r_sr, c_sr;

    fpx_insn_decoder #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .instr_i(instr), .op_o(r_op), .unsup_o(r_un),
        .core_t_o(r_ct), .core_n_o(r_cn), .dreg_d_o(r_dd), .dreg_n_o(r_dn),
        .dreg_m_o(r_dm), .sreg_o(r_sr));

    fpx_insn_decoder #(.REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst), .instr_i(instr), .op_o(c_op), .unsup_o(c_un),
        .core_t_o(c_ct), .core_n_o(c_cn), .dreg_d_o(c_dd), .dreg_n_o(c_dn),
        .dreg_m_o(c_dm), .sreg_o(c_sr));

    // expected {op, unsup, sidx} from the requirement text
    function automatic logic [9:0] expect_dec(logic [31:0] w);
        logic [3:0] op;
        logic       un;
        logic [4:0] si;
        logic in6, in7, tail95;
        in6 = (w[27:25] == 3'd6);
        in7 = (w[27:25] == 3'd7) && (w[24] == 1'b0);
        tail95 = (w[11:9] == 3'd5) && w[8] && !w[4];
        op = 4'd0; si = 5'd0;
        un = in6 || in7;
        if (in7 && !w[23] && !w[21] && w[11:8] == 4'hA && w[6:5] == 2'd0 && w[4] && w[3:0] == 4'd0)
            op = w[20] ? 4'd2 : 4'd1;
        if (in7 && w[23] && tail95 && w[6] && w[21:19] == 3'd7 && w[18:16] == 3'd5) op = 4'd4;
        if (in7 && w[23] && tail95 && w[6] && w[7] && w[21:19] == 3'd7 && w[18:16] == 3'd0) op = 4'd3;
        if (in7 && w[23] && tail95 && !w[6] && w[21:20] == 2'd0) op = 4'd8;
        if (in7 && !w[23] && w[21] && tail95) begin
            if (w[20] && !w[6]) op = 4'd5;
            if (w[20] && w[6])  op = 4'd6;
            if (!w[20] && !w[6]) op = 4'd7;
        end
        if (in7 && w[23] && tail95 && w[6] && w[21:20] == 2'd3 && w[19:16] == 4'd4) op = 4'd9;
        if (in7 && w[23:20] == 4'hF && w[19:16] == 4'd1 && w[11:8] == 4'hA && w[7:5] == 3'd0 &&
            w[4] && w[3:0] == 4'd0 && w[15:12] == 4'hF) op = 4'd10;
        if (in6 && w[27:24] == 4'hC && !w[23] && w[22] && w[11:8] == 4'hB && w[7:6] == 2'd0 && w[4])
            op = w[20] ? 4'd12 : 4'd11;
        if (op != 4'd0) un = 1'b0;
        if (op == 4'd1 || op == 4'd2) si = {w[19:16], w[7]};
        if (op == 4'd4) si = {w[15:12], w[22]};
        if (op == 4'd3) si = {w[3:0], w[5]};
        return {op, un, si};
    endfunction

    function automatic string tag_of(logic [3:0] op, logic un, logic [31:0] w);
        if (un) return (w[23:20] == 4'hF && w[19:16] == 4'd1) ? "R6" : "R8";
        case (op)
            4'd0: return "R1";
            4'd1, 4'd2: return "R2";
            4'd3, 4'd4: return "R3";
            4'd5, 4'd6, 4'd7, 4'd8: return "R4";
            4'd9: return "R5";
            4'd10: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [31:0] shape(int k, logic [31:0] base);
        logic [31:0] w;
        w = base;
        if (k >= 1 && k <= 7) w[27:24] = 4'hE;
        case (k)
            1: begin w[23] = 0; w[21] = 0; w[11:8] = 4'hA; w[6:5] = 0; w[4] = 1; w[3:0] = 0; end
            2: begin w[23] = 1; w[21:19] = 7; w[18:16] = 5; w[11:9] = 5; w[8] = 1; w[6] = 1; w[4] = 0; end
            3: begin w[23] = 1; w[21:19] = 7; w[18:16] = 0; w[11:9] = 5; w[8] = 1; w[7] = 1; w[6] = 1; w[4] = 0; end
            4: begin w[23] = 1; w[21:20] = 0; w[11:9] = 5; w[8] = 1; w[6] = 0; w[4] = 0; end
            5: begin w[23] = 1; w[21:20] = 3; w[19:16] = 4; w[11:9] = 5; w[8] = 1; w[6] = 1; w[4] = 0; end
            6: begin w[23:20] = 4'hF; w[19:16] = 1; w[11:8] = 4'hA; w[7:5] = 0; w[4] = 1; w[3:0] = 0;
                     if (base[31]) w[15:12] = 4'hF; end
            7: begin w[23] = 0; w[21] = 1; w[11:9] = 5; w[8] = 1; w[4] = 0; end
            8: begin w[27:24] = 4'hC; w[23] = 0; w[22] = 1; w[11:8] = 4'hB; w[7:6] = 0; w[4] = 1; end
            9: w[27:24] = 4'hF;
            default: ;
        endcase
        return w;
    endfunction

    task automatic report(string tag, string what, logic [31:0] w, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s word=%h actual=%h expected=%h", tag, what, w, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] w);
        logic [9:0] e;
        string t;
        e = expect_dec(w);
        t = tag_of(e[9:6], e[5], w);
        @(negedge clk);
        instr = w;
        #1;
        report(t, "comb decode", w, {6'd0, c_op, c_un, c_sr}, {6'd0, e});
        // R9 raw fields
        report("R9", "fields", w, {c_ct, c_cn, c_dd, c_dm},
               {w[15:12], w[19:16], w[15:12], w[3:0]});
        report("R9", "dn field", w, {12'd0, c_dn}, {12'd0, w[19:16]});
        @(posedge clk);
        #1;
        // R10 registered copy one edge later
        report("R10", "registered decode", w, {2'd0, r_op, r_un, r_sr, r_ct}, {2'd0, e, w[15:12]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        instr = shape(8, 32'h0000_3a51);
        repeat (3) @(posedge clk);
        #1;
        report("R10", "reset hold", instr, {r_op, r_un, r_sr, r_ct, 2'd0}, 16'd0);
        @(negedge clk);
        rst = 1'b0;

        apply(32'h1234_5678);                          // type 0
        apply(32'hEF00_0000);                          // soft interrupt
        apply(shape(1, 32'h0012_3480) & ~32'h0010_0000); // core to single
        apply(shape(1, 32'h0015_5080));                // single to core
        apply(shape(2, 32'h0040_9000));                // d2i with D set
        apply(shape(3, 32'h0000_002B));                // i2d with M set
        apply(shape(6, 32'h8000_0000));                // status, rt = F
        apply(shape(6, 32'h0000_3000));                // status, rt = 3
        apply(shape(7, 32'h0000_0040) & ~32'h0010_0000); // bit20=0, bit6=1
        apply(shape(7, 32'h0010_0000));                // add
        apply(shape(8, 32'h0000_0000));                // two core to double
        apply(shape(8, 32'h0010_0000));                // double to two core
        apply(shape(8, 32'h0080_0000) | 32'h0080_0000); // still paired, check
        apply(32'h0C80_0B10);                          // type 6 with bit 23 set
        apply(shape(5, 32'h0000_1002));                // compare
        apply(shape(4, 32'h0000_2003));                // divide

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int k;
            k = $urandom_range(0, 10);
            if (k == 10) begin
                w = shape($urandom_range(1, 8), $urandom);
                w[$urandom_range(0, 23)] ^= 1'b1;
            end else begin
                w = shape(k, $urandom);
            end
            apply(w);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule